// File: doc/BRIEF.md
# Tripled-Rate Asynchronous Serial Transmitter

This block sends one asynchronous serial character at a slow line rate, for example 1200 baud, using a serializer that steps at three times that rate. Each logical bit on the line is made of three equal sub-bits, and each sub-bit lasts `SUB_DIV` clock cycles. At a 180 MHz system clock and a 1200 baud link the sub-bit period is 50,000 clocks, giving 3600 sub-bits per second.

A character is offered on a valid/ready input. The character is taken on the clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole time a frame is on the line, so the sender holds its character and waits. While `in_ready` is low, `in_valid`, the data and the configuration pins are ignored.

The frame starts with one native low start sub-bit from the serializer. A payload follows, shifted least significant first:
- two low sub-bits that extend the start bit to three sub-bits;
- the data bits, three sub-bits each;
- optionally a parity bit, three sub-bits;
- optionally an extra stop bit, three high sub-bits.

The payload length is (data_bits + parity + extra_stop)×3 + 2, at most 32 sub-bits. After the payload the line stays high for three native stop sub-bits, and then `busy` drops. The configuration pins are captured together with the data.

Top module: `tri_uart_tx`

## Requirements
- R1: After reset, `tx` is high, `busy` is low and `in_ready` is high. The line stays high whenever `busy` is low.
- R2: A character is accepted only on an edge where `in_valid` and `in_ready` are both high. `in_ready` equals the inverse of `busy`. A `busy` frame begins on the cycle after acceptance. `in_valid` pulses while `busy` is high are ignored and start no frame.
- R3: Every sub-bit holds the line steady for exactly `SUB_DIV` clock cycles. Every logical bit spans three sub-bits.
- R4: The start bit is three low sub-bits: one native sub-bit followed by two extension sub-bits.
- R5: Data bits go out least significant bit first. The data width is `cfg_width`+5, so the codes 0, 1, 2 and 3 select 5, 6, 7 and 8 bits. Unused high bits of `in_data` have no effect.
- R6: With `cfg_par_en`=1, three parity sub-bits follow the data immediately. Parity is computed over the selected data bits only. `cfg_par_odd`=0 selects even parity (the XOR of the data bits). `cfg_par_odd`=1 selects odd parity (its inverse).
- R7: With `cfg_two_stop`=1, three extra high sub-bits follow the parity, or follow the data when parity is off.
- R8: After the payload the line is high for three sub-bits. `busy` then falls, exactly (data_bits+parity+extra_stop)×3+6 sub-bit periods after acceptance.
- R9: The data and configuration are captured at acceptance. Changes to them during a frame do not alter the frame on the line.
- R10: The largest case fits: 8 data bits with parity and a second stop bit use a 32-sub-bit payload and 36 sub-bit periods in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can take a character (not busy) |
| in_data | input | 8 | Character, least significant bit sent first |
| cfg_width | input | 2 | Data width code, width = code + 5 |
| cfg_par_en | input | 1 | Append parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | Append a second stop bit |
| tx | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |

## Verification
Directed frames cover each data width code, each parity choice and each stop count, including the largest 8-bit frame with parity and two stops. These frames tell a misplaced parity or stop triple apart from a wrong data bit order. Random frames use random bytes and configurations. During each random frame the data, configuration and `in_valid` pins are scrambled, which separates a design that captures its inputs at acceptance from one that reads them live. Every tick of every frame is compared with a bench-built sub-bit image, so a wrong sub-bit length, an off-by-one in the total length or a stray acceptance while busy shows up as a mismatch in a named frame region.

// File: rtl/tx3_pkg.sv
package tx3_pkg;
  localparam int SUB_PER_BIT = 3;
  localparam int DATA_MAX    = 8;
  localparam int DATA_MIN    = 5;
  localparam int PAYLOAD_MAX = 32;
  localparam int FRAME_W     = 1 + PAYLOAD_MAX + SUB_PER_BIT;
  localparam int CNT_W       = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [1:0] width_sel;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
  } tx3_cfg_t;
endpackage

// File: rtl/tx3_tick.sv
module tx3_tick #(
  parameter int SUB_DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int DW = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(SUB_DIV - 1);

  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= '0;
    else if (run)      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  // a freshly restarted period never ends on the next cycle
  p_restart_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);
endmodule

// File: rtl/tx3_framer.sv
module tx3_framer
  import tx3_pkg::*;
(
  input  logic [DATA_MAX-1:0]    data,
  input  tx3_cfg_t               cfg,
  output logic [PAYLOAD_MAX-1:0] payload,
  output logic [CNT_W-1:0]       total_sub
);
  logic [3:0]          nbits;
  logic [DATA_MAX-1:0] used;
  logic                par_bit;

  always_comb begin
    nbits = 4'(DATA_MIN) + {2'b00, cfg.width_sel};
    for (int i = 0; i < DATA_MAX; i++) used[i] = (i < int'(nbits)) ? data[i] : 1'b0;
    par_bit = (^used) ^ cfg.par_odd;
    total_sub = CNT_W'((int'(nbits) + int'(cfg.par_en) + int'(cfg.two_stop)) * SUB_PER_BIT
                       + SUB_PER_BIT + SUB_PER_BIT);
  end

  for (genvar j = 0; j < PAYLOAD_MAX; j++) begin : g_pos
    localparam int SLOT = (j - 2) / SUB_PER_BIT;
    if (j < 2) begin : g_ext
      assign payload[j] = 1'b0;
    end else if (SLOT < DATA_MAX) begin : g_dat
      assign payload[j] = (SLOT < int'(nbits)) ? data[SLOT]
                        : ((SLOT == int'(nbits)) && cfg.par_en) ? par_bit : 1'b1;
    end else if (SLOT == DATA_MAX) begin : g_par
      assign payload[j] = (cfg.par_en && (int'(nbits) == DATA_MAX)) ? par_bit : 1'b1;
    end else begin : g_hi
      assign payload[j] = 1'b1;
    end
  end
endmodule

// File: rtl/tx3_shifter.sv
module tx3_shifter
  import tx3_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   count_in,
  input  logic               tick,
  output logic               line,
  output logic               busy
);
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   remaining;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '1;
      remaining <= '0;
      busy      <= 1'b0;
    end else if (load) begin
      shreg     <= frame_in;
      remaining <= count_in;
      busy      <= 1'b1;
    end else if (busy && tick) begin
      shreg     <= {1'b1, shreg[FRAME_W-1:1]};
      remaining <= remaining - 1'b1;
      if (remaining == CNT_W'(1)) busy <= 1'b0;
    end
  end

  assign line = busy ? shreg[0] : 1'b1;

  p_count_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (remaining != '0));
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line);
  p_line_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick) && !$past(load)) |-> (line == $past(line)));
endmodule

// File: rtl/tri_uart_tx.sv
module tri_uart_tx
  import tx3_pkg::*;
#(
  parameter int SUB_DIV = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic [1:0] cfg_width,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  output logic       tx,
  output logic       busy
);
  tx3_cfg_t                cfg;
  logic [PAYLOAD_MAX-1:0]  payload;
  logic [CNT_W-1:0]        total_sub;
  logic [FRAME_W-1:0]      frame;
  logic                    accept;
  logic                    tick;

  assign cfg      = '{width_sel: cfg_width, par_en: cfg_par_en,
                      par_odd: cfg_par_odd, two_stop: cfg_two_stop};
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign frame    = {{SUB_PER_BIT{1'b1}}, payload, 1'b0};

  tx3_framer i_framer (
    .data      (in_data),
    .cfg       (cfg),
    .payload   (payload),
    .total_sub (total_sub)
  );

  tx3_tick #(.SUB_DIV(SUB_DIV)) i_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .run     (busy),
    .tick    (tick)
  );

  tx3_shifter i_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .frame_in (frame),
    .count_in (total_sub),
    .tick     (tick),
    .line     (tx),
    .busy     (busy)
  );

  p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx);
  p_end_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tx));
endmodule

// File: tb/test_tri_uart_tx.sv
module test_tri_uart_tx;
  localparam int DIV = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic [1:0] cfg_width = 2'd0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       tx;
  logic       busy;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  tri_uart_tx #(.SUB_DIV(DIV)) i_tri_uart_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_width(cfg_width), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop), .tx(tx), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected sub-bit image: region codes 4=start 5=data 6=parity 7=extra stop 8=final stop
  bit exp_bit[40];
  int exp_reg[40];
  int exp_len;

  task automatic build(input logic [7:0] d, input int w, input bit pe, input bit po,
                       input bit ts);
    int n = w + 5;
    int k = 0;
    bit p = po;
    for (int i = 0; i < n; i++) p ^= d[i];
    for (int s = 0; s < 3; s++) begin exp_bit[k] = 0; exp_reg[k] = 4; k++; end
    for (int i = 0; i < n; i++)
      for (int s = 0; s < 3; s++) begin exp_bit[k] = d[i]; exp_reg[k] = 5; k++; end
    if (pe) for (int s = 0; s < 3; s++) begin exp_bit[k] = p; exp_reg[k] = 6; k++; end
    if (ts) for (int s = 0; s < 3; s++) begin exp_bit[k] = 1; exp_reg[k] = 7; k++; end
    for (int s = 0; s < 3; s++) begin exp_bit[k] = 1; exp_reg[k] = 8; k++; end
    exp_len = k;
  endtask

  task automatic send(input logic [7:0] d, input int w, input bit pe, input bit po,
                      input bit ts, input bit scramble);
    int err[9];
    int first_act[9];
    int first_exp[9];
    int r3err = 0;
    int busy_err = 0;
    logic prev = 1'b1;
    int total;
    for (int r = 0; r < 9; r++) begin err[r] = 0; first_act[r] = 0; first_exp[r] = 0; end
    build(d, w, pe, po, ts);
    total = exp_len * DIV;
    @(negedge clk);
    chk(in_ready === 1'b1, "R2", "ready before offer", int'(in_ready), 1);
    in_data = d; cfg_width = 2'(w); cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = ts;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int j = 0; j <= total; j++) begin
      if (j < total) begin
        int i = j / DIV;
        int r = exp_reg[i];
        if (tx !== exp_bit[i]) begin
          if (err[r] == 0) begin first_act[r] = int'(tx); first_exp[r] = int'(exp_bit[i]); end
          err[r]++;
        end
        if ((j % DIV) != 0 && tx !== prev) r3err++;
        if (busy !== 1'b1 || in_ready !== 1'b0) busy_err++;
        prev = tx;
      end else begin
        chk(busy === 1'b0 && in_ready === 1'b1, "R8", "busy falls at end of frame",
            int'(busy), 0);
        chk(tx === 1'b1, "R1", "line idle after frame", int'(tx), 1);
      end
      if (scramble) begin
        in_data      = 8'($urandom);
        cfg_width    = 2'($urandom);
        cfg_par_en   = 1'($urandom);
        cfg_par_odd  = 1'($urandom);
        cfg_two_stop = 1'($urandom);
        in_valid     = (j < total - 1) ? 1'($urandom) : 1'b0;
      end
      if (j < total) @(negedge clk);
    end
    in_valid = 1'b0;
    chk(busy_err == 0, "R2", "busy/not-ready through frame", busy_err, 0);
    chk(r3err == 0, "R3", "line steady inside sub-bit", r3err, 0);
    chk(err[4] == 0, "R4", "start sub-bits", first_act[4], first_exp[4]);
    chk(err[5] == 0, scramble ? "R5 R9" : "R5", "data sub-bits", first_act[5], first_exp[5]);
    if (pe) chk(err[6] == 0, "R6", "parity sub-bits", first_act[6], first_exp[6]);
    if (ts) chk(err[7] == 0, "R7", "extra stop sub-bits", first_act[7], first_exp[7]);
    chk(err[8] == 0, "R8", "final stop sub-bits", first_act[8], first_exp[8]);
    // one more idle window: a pulse accepted while busy would have started a frame here
    repeat (DIV) begin
      @(negedge clk);
      if (busy !== 1'b0 || tx !== 1'b1) busy_err++;
    end
    chk(busy_err == 0, "R2", "no stray frame after busy pulses", busy_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    chk(tx === 1'b1, "R1", "tx in reset", int'(tx), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx === 1'b1 && busy === 1'b0, "R1", "idle after reset", int'(busy), 0);
    chk(in_ready === 1'b1, "R1", "ready after reset", int'(in_ready), 1);

    send(8'hE6, 0, 0, 0, 0, 0);   // 5N1, high bits must not leak
    send(8'h5A, 3, 1, 0, 1, 0);   // R10 largest: 8E2
    chk(exp_len == 36, "R10", "largest frame sub-bit count", exp_len, 36);
    send(8'h4B, 2, 1, 1, 0, 0);   // 7O1
    send(8'h15, 1, 1, 0, 1, 1);   // 6E2 with scrambled pins
    send(8'hFF, 3, 1, 1, 1, 1);   // 8O2 all ones
    send(8'h00, 3, 0, 0, 1, 0);   // 8N2 all zeros
    for (int t = 0; t < 30; t++)
      send(8'($urandom), int'(2'($urandom)), 1'($urandom), 1'($urandom),
           1'($urandom), 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule